// File: doc/BRIEF.md
# Priority-Aware Deficit Round Robin Scheduler with Dual-Rate Shaping

This block is one scheduling node. It picks which of several input queues sends its next packet toward a single output. Each queue presents three things: a non-empty flag, the length of its head packet and a priority level. Every queue is gated by two token buckets. The committed bucket enforces the guaranteed rate and the excess bucket enforces the extra rate allowed on top of it. A buffer manager upstream owns the packet data. The node only decides, and it issues one grant at a time on a valid/ready interface that carries the winning queue index and the packet length.

The decision runs in three steps. First the node splits the queues into two classes: those that can pay for their head packet from committed tokens, and those that can pay only from excess tokens. The committed class is always considered first. Within the chosen class, the highest priority level present wins outright. Queues that tie at that level are split by a selectable discipline: plain round robin, deficit weighted round robin, or fixed lowest-index priority. All queues pass through one decision path, so packets from one queue always leave in order. A downstream backpressure flag stops new grants for as long as it is held.

Top module: `prio_dwrr_sched`

## Requirements
- R1: After reset `grantValid` is low, and both buckets of every queue are empty. No grant is issued before the first refill tick, even with every queue non-empty.
- R2: A higher `qPrio` value is a higher priority. When queues are in the same token class, a queue at a higher level is always granted before any queue at a lower level.
- R3: A queue is committed-eligible when its committed tokens are at least its head length, and excess-eligible when only its excess tokens are. An excess-eligible queue is granted only if no queue is committed-eligible, whatever the priorities. A grant debits the head length from the bucket of the class it was won in.
- R4: On each cycle with `refillTick` high, every bucket gains its own step value and is clamped at its own cap. A queue whose head length exceeds both of its token counts is never granted.
- R5: With `mode` = 0 (round robin), equal candidates are served in index order. The search starts from the queue after the last one granted, wrapping from NQ-1 to 0. After reset the first candidate searched is queue 0.
- R6: With `mode` = 2 or 3 (fixed order), the lowest-index candidate among equals wins on every grant.
- R7: With `mode` = 1 (deficit round robin), the current queue's deficit must be at least its head length for it to send, and each grant subtracts the length from the deficit. A queue that cannot send gets its quantum added to its deficit, and the turn passes to the next index. That step takes one cycle with no grant. Two always-busy queues with quanta 10 and 30 and 10-byte packets are granted in the order 0,1,1,1 repeating.
- R8: The deficit of a queue whose `qNonEmpty` bit is low is cleared to zero.
- R9: While `portBackpressure` is high, no new grant is issued. Granting resumes once it falls.
- R10: A grant holds `grantValid`, `grantQueue` and `grantLen` stable until `grantReady` is high. `grantLen` equals the head length the granted queue showed when it was chosen.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| mode | input | 2 | Tie-break discipline: 0 round robin, 1 deficit round robin, 2/3 fixed order |
| qNonEmpty | input | NQ | One bit per queue: queue holds a packet |
| qHeadLen | input | NQ*LW | Head packet length per queue, queue i at bits i*LW |
| qPrio | input | NQ*PW | Priority level per queue, larger is more urgent |
| qQuantum | input | NQ*LW | Deficit quantum per queue |
| cirStep | input | NQ*TW | Committed bucket refill amount per tick |
| eirStep | input | NQ*TW | Excess bucket refill amount per tick |
| cirCap | input | NQ*TW | Committed bucket ceiling |
| eirCap | input | NQ*TW | Excess bucket ceiling |
| refillTick | input | 1 | Refill strobe for all buckets |
| portBackpressure | input | 1 | Downstream not ready; blocks new grants |
| grantReady | input | 1 | Consumer accepts the current grant |
| grantValid | output | 1 | A grant is presented |
| grantQueue | output | IW | Index of the granted queue |
| grantLen | output | LW | Length of the granted packet |

## Verification
The bench builds the block with its defaults: eight queues, 8-bit lengths, four priority levels and 12-bit token counters. Eight queues are enough to see the round-robin pointer wrap past the top index. Four levels leave room for a high, a middle and a base level in one scenario. A 12-bit counter lets a single refill fund a long run of grants, while an 8-bit length still allows the one-unit boundary of 120 tokens against a 121-byte packet. Small quanta of 10 and 30 make the deficit order short enough to list in full, and a deficit left over after a grant becomes visible as a missing visit cycle.

// File: rtl/prio_dwrr_sched_pkg.sv
`timescale 1ns/1ps
package prio_dwrr_sched_pkg;

  typedef enum logic [1:0] {
    MODE_RR   = 2'd0,
    MODE_DWRR = 2'd1,
    MODE_SP   = 2'd2,
    MODE_SPX  = 2'd3
  } schedMode_t;

  // strobes from control to datapath, one decision per cycle
  typedef struct packed {
    logic issue;         // load a grant and debit the winning bucket
    logic visit;         // add quantum to the winner and pass the turn
    logic useExcess;     // winner was chosen from the excess class
    logic debitDeficit;  // deficit mode: subtract the length on issue
    logic accept;        // handshake completes this cycle
  } schedStrobe_t;

endpackage

// File: rtl/prio_dwrr_sched_ctrl.sv
`timescale 1ns/1ps
module prio_dwrr_sched_ctrl
  import prio_dwrr_sched_pkg::*;
#(
  parameter int NQ = 8,
  parameter int LW = 8,
  parameter int PW = 2,
  parameter int TW = 12,
  parameter int DW = 10,
  parameter int IW = 3
) (
  input  logic [1:0]       mode,
  input  logic [NQ-1:0]    qNonEmpty,
  input  logic [NQ*LW-1:0] qHeadLen,
  input  logic [NQ*PW-1:0] qPrio,
  input  logic [NQ*TW-1:0] cirTok,
  input  logic [NQ*TW-1:0] eirTok,
  input  logic [NQ*DW-1:0] deficit,
  input  logic [IW-1:0]    turnPtr,
  input  logic [IW-1:0]    lastPtr,
  input  logic             grantValid,
  input  logic             grantReady,
  input  logic             portBackpressure,
  output schedStrobe_t     stb,
  output logic [IW-1:0]    winIdx
);

  logic [LW-1:0] lenOf [NQ];
  logic [NQ-1:0] commitOk, excessOk, classVec, cand;
  logic          anyCommit;
  logic [PW-1:0] topLvl;
  logic [IW-1:0] startIdx, pickIdx;
  logic          found, enough, decide, dwrr;
  schedMode_t    modeSel;

  assign modeSel = schedMode_t'(mode);
  assign dwrr    = (modeSel == MODE_DWRR);

  // token class of every queue
  always_comb begin
    for (int i = 0; i < NQ; i++) begin
      lenOf[i]    = qHeadLen[i*LW +: LW];
      commitOk[i] = qNonEmpty[i] && (cirTok[i*TW +: TW] >= TW'(lenOf[i]));
      excessOk[i] = qNonEmpty[i] && (eirTok[i*TW +: TW] >= TW'(lenOf[i]));
    end
  end

  assign anyCommit = |commitOk;
  assign classVec  = anyCommit ? commitOk : excessOk;

  // highest level present in the chosen class
  always_comb begin
    topLvl = '0;
    for (int i = 0; i < NQ; i++) begin
      if (classVec[i] && (qPrio[i*PW +: PW] > topLvl)) topLvl = qPrio[i*PW +: PW];
    end
  end

  always_comb begin
    for (int i = 0; i < NQ; i++) begin
      cand[i] = classVec[i] && (qPrio[i*PW +: PW] == topLvl);
    end
  end

  // where the rotating search begins
  always_comb begin
    case (modeSel)
      MODE_RR:   startIdx = (lastPtr == IW'(NQ-1)) ? '0 : IW'(lastPtr + 1'b1);
      MODE_DWRR: startIdx = turnPtr;
      default:   startIdx = '0;
    endcase
  end

  // first candidate at or after startIdx; scanned from far to near
  always_comb begin
    found   = 1'b0;
    pickIdx = '0;
    for (int k = NQ-1; k >= 0; k--) begin
      if (cand[(int'(startIdx) + k) % NQ]) begin
        found   = 1'b1;
        pickIdx = IW'((int'(startIdx) + k) % NQ);
      end
    end
  end

  assign enough = deficit[pickIdx*DW +: DW] >= DW'(lenOf[pickIdx]);
  assign decide = !grantValid && !portBackpressure && found;
  assign winIdx = pickIdx;

  always_comb begin
    stb              = '0;
    stb.issue        = decide && (!dwrr || enough);
    stb.visit        = decide && dwrr && !enough;
    stb.useExcess    = !anyCommit;
    stb.debitDeficit = dwrr;
    stb.accept       = grantValid && grantReady;
  end

endmodule

// File: rtl/prio_dwrr_sched_dp.sv
`timescale 1ns/1ps
module prio_dwrr_sched_dp
  import prio_dwrr_sched_pkg::*;
#(
  parameter int NQ = 8,
  parameter int LW = 8,
  parameter int TW = 12,
  parameter int DW = 10,
  parameter int IW = 3
) (
  input  logic             clk,
  input  logic             rstN,
  input  schedStrobe_t     stb,
  input  logic [IW-1:0]    winIdx,
  input  logic [NQ-1:0]    qNonEmpty,
  input  logic [NQ*LW-1:0] qHeadLen,
  input  logic [NQ*LW-1:0] qQuantum,
  input  logic [NQ*TW-1:0] cirStep,
  input  logic [NQ*TW-1:0] eirStep,
  input  logic [NQ*TW-1:0] cirCap,
  input  logic [NQ*TW-1:0] eirCap,
  input  logic             refillTick,
  output logic [NQ*TW-1:0] cirTok,
  output logic [NQ*TW-1:0] eirTok,
  output logic [NQ*DW-1:0] deficit,
  output logic [IW-1:0]    turnPtr,
  output logic [IW-1:0]    lastPtr,
  output logic             grantValid,
  output logic [IW-1:0]    grantQueue,
  output logic [LW-1:0]    grantLen
);

  logic [TW-1:0] cirNext [NQ];
  logic [TW-1:0] eirNext [NQ];
  logic [DW-1:0] defNext [NQ];

  for (genvar g = 0; g < NQ; g++) begin : gQueue
    logic          hitG, visitG;
    logic [LW-1:0] lenG;
    logic [TW:0]   cSum, eSum;
    logic [DW-1:0] dVal;

    assign lenG   = qHeadLen[g*LW +: LW];
    assign hitG   = stb.issue && (winIdx == IW'(g));
    assign visitG = stb.visit && (winIdx == IW'(g));

    // debit, refill, then clamp at the ceiling
    always_comb begin
      cSum = {1'b0, cirTok[g*TW +: TW]};
      eSum = {1'b0, eirTok[g*TW +: TW]};
      if (hitG && !stb.useExcess) cSum = cSum - (TW+1)'(lenG);
      if (hitG &&  stb.useExcess) eSum = eSum - (TW+1)'(lenG);
      if (refillTick) begin
        cSum = cSum + {1'b0, cirStep[g*TW +: TW]};
        eSum = eSum + {1'b0, eirStep[g*TW +: TW]};
      end
      if (cSum > {1'b0, cirCap[g*TW +: TW]}) cSum = {1'b0, cirCap[g*TW +: TW]};
      if (eSum > {1'b0, eirCap[g*TW +: TW]}) eSum = {1'b0, eirCap[g*TW +: TW]};
    end

    always_comb begin
      dVal = deficit[g*DW +: DW];
      if (!qNonEmpty[g])                  dVal = '0;
      else if (visitG)                    dVal = dVal + DW'(qQuantum[g*LW +: LW]);
      else if (hitG && stb.debitDeficit)  dVal = dVal - DW'(lenG);
    end

    assign cirNext[g] = cSum[TW-1:0];
    assign eirNext[g] = eSum[TW-1:0];
    assign defNext[g] = dVal;
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cirTok     <= '0;
      eirTok     <= '0;
      deficit    <= '0;
      turnPtr    <= '0;
      lastPtr    <= IW'(NQ-1);
      grantValid <= 1'b0;
      grantQueue <= '0;
      grantLen   <= '0;
    end else begin
      for (int i = 0; i < NQ; i++) begin
        cirTok[i*TW +: TW]  <= cirNext[i];
        eirTok[i*TW +: TW]  <= eirNext[i];
        deficit[i*DW +: DW] <= defNext[i];
      end
      if (stb.visit) begin
        turnPtr <= (winIdx == IW'(NQ-1)) ? '0 : IW'(winIdx + 1'b1);
      end else if (stb.issue && stb.debitDeficit) begin
        turnPtr <= winIdx;
      end
      if (stb.issue) begin
        lastPtr    <= winIdx;
        grantValid <= 1'b1;
        grantQueue <= winIdx;
        grantLen   <= qHeadLen[winIdx*LW +: LW];
      end else if (stb.accept) begin
        grantValid <= 1'b0;
      end
    end
  end

endmodule

// File: rtl/prio_dwrr_sched.sv
`timescale 1ns/1ps
module prio_dwrr_sched
  import prio_dwrr_sched_pkg::*;
#(
  parameter int NQ = 8,
  parameter int LW = 8,
  parameter int PW = 2,
  parameter int TW = 12,
  localparam int IW = $clog2(NQ),
  localparam int DW = LW + 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [1:0]       mode,
  input  logic [NQ-1:0]    qNonEmpty,
  input  logic [NQ*LW-1:0] qHeadLen,
  input  logic [NQ*PW-1:0] qPrio,
  input  logic [NQ*LW-1:0] qQuantum,
  input  logic [NQ*TW-1:0] cirStep,
  input  logic [NQ*TW-1:0] eirStep,
  input  logic [NQ*TW-1:0] cirCap,
  input  logic [NQ*TW-1:0] eirCap,
  input  logic             refillTick,
  input  logic             portBackpressure,
  input  logic             grantReady,
  output logic             grantValid,
  output logic [IW-1:0]    grantQueue,
  output logic [LW-1:0]    grantLen
);

  schedStrobe_t     stb;
  logic [IW-1:0]    winIdx, turnPtr, lastPtr;
  logic [NQ*TW-1:0] cirTok, eirTok;
  logic [NQ*DW-1:0] deficit;

  prio_dwrr_sched_ctrl #(
    .NQ(NQ), .LW(LW), .PW(PW), .TW(TW), .DW(DW), .IW(IW)
  ) uCtrl (
    .mode(mode), .qNonEmpty(qNonEmpty), .qHeadLen(qHeadLen), .qPrio(qPrio),
    .cirTok(cirTok), .eirTok(eirTok), .deficit(deficit),
    .turnPtr(turnPtr), .lastPtr(lastPtr),
    .grantValid(grantValid), .grantReady(grantReady),
    .portBackpressure(portBackpressure),
    .stb(stb), .winIdx(winIdx)
  );

  prio_dwrr_sched_dp #(
    .NQ(NQ), .LW(LW), .TW(TW), .DW(DW), .IW(IW)
  ) uDp (
    .clk(clk), .rstN(rstN), .stb(stb), .winIdx(winIdx),
    .qNonEmpty(qNonEmpty), .qHeadLen(qHeadLen), .qQuantum(qQuantum),
    .cirStep(cirStep), .eirStep(eirStep), .cirCap(cirCap), .eirCap(eirCap),
    .refillTick(refillTick),
    .cirTok(cirTok), .eirTok(eirTok), .deficit(deficit),
    .turnPtr(turnPtr), .lastPtr(lastPtr),
    .grantValid(grantValid), .grantQueue(grantQueue), .grantLen(grantLen)
  );

endmodule

// File: rtl/prio_dwrr_sched_checker.sv
`timescale 1ns/1ps
module prio_dwrr_sched_checker #(
  parameter int NQ = 8,
  parameter int LW = 8,
  parameter int TW = 12,
  parameter int IW = 3
) (
  input logic             clk,
  input logic             rstN,
  input logic             grantValid,
  input logic             grantReady,
  input logic [IW-1:0]    grantQueue,
  input logic [LW-1:0]    grantLen,
  input logic             portBackpressure,
  input logic [NQ-1:0]    qNonEmpty,
  input logic [NQ*LW-1:0] qHeadLen,
  input logic [NQ*TW-1:0] cirTok,
  input logic [NQ*TW-1:0] eirTok,
  input logic [NQ*TW-1:0] cirCap,
  input logic [NQ*TW-1:0] eirCap
);

  // R10: a pending grant is held unchanged until taken
  assert_grant_hold_R10: assert property (@(posedge clk) disable iff (!rstN)
    grantValid && !grantReady |=> grantValid && $stable(grantQueue) && $stable(grantLen))
    else $error("grant changed while waiting for ready");

  // R9: backpressure blocks a new grant
  assert_bp_block_R9: assert property (@(posedge clk) disable iff (!rstN)
    portBackpressure && !grantValid |=> !grantValid)
    else $error("grant issued under backpressure");

  // R10: a new grant names a queue that was non-empty when chosen
  assert_grant_nonempty_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantValid) |-> |(($past(qNonEmpty) >> grantQueue) & NQ'(1)))
    else $error("grant to an empty queue");

  // R10: the granted length is the head length seen at decision time
  assert_grant_len_R10: assert property (@(posedge clk) disable iff (!rstN)
    $rose(grantValid) |-> grantLen == LW'($past(qHeadLen) >> (grantQueue * LW)))
    else $error("grant length does not match head length");

  // R4: no bucket ever holds more than its ceiling
  always @(posedge clk) begin
    if (rstN) begin
      for (int i = 0; i < NQ; i++) begin
        assert_bucket_cap_R4: assert ((cirTok[i*TW +: TW] <= cirCap[i*TW +: TW]) &&
                                      (eirTok[i*TW +: TW] <= eirCap[i*TW +: TW]))
          else $error("bucket above ceiling on queue %0d", i);
      end
    end
  end

endmodule

bind prio_dwrr_sched prio_dwrr_sched_checker #(
  .NQ(NQ), .LW(LW), .TW(TW), .IW(IW)
) uChk (
  .clk(clk), .rstN(rstN), .grantValid(grantValid), .grantReady(grantReady),
  .grantQueue(grantQueue), .grantLen(grantLen), .portBackpressure(portBackpressure),
  .qNonEmpty(qNonEmpty), .qHeadLen(qHeadLen), .cirTok(cirTok), .eirTok(eirTok),
  .cirCap(cirCap), .eirCap(eirCap)
);

// File: tb/prio_dwrr_sched_test.sv
`timescale 1ns/1ps
module prio_dwrr_sched_test;
  localparam int NQ = 8, LW = 8, PW = 2, TW = 12, IW = 3;

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic             rstN, refillTick, portBackpressure, grantReady;
  logic [1:0]       mode;
  logic [NQ-1:0]    qNonEmpty;
  logic [NQ*LW-1:0] qHeadLen, qQuantum;
  logic [NQ*PW-1:0] qPrio;
  logic [NQ*TW-1:0] cirStep, eirStep, cirCap, eirCap;
  logic             grantValid;
  logic [IW-1:0]    grantQueue;
  logic [LW-1:0]    grantLen;

  bit ne [NQ];
  int hLen [NQ], pri [NQ], quant [NQ], cS [NQ], eS [NQ], cC [NQ], eC [NQ];

  int total = 0;
  int bad   = 0;

  prio_dwrr_sched uut (
    .clk(clk), .rstN(rstN), .mode(mode), .qNonEmpty(qNonEmpty),
    .qHeadLen(qHeadLen), .qPrio(qPrio), .qQuantum(qQuantum),
    .cirStep(cirStep), .eirStep(eirStep), .cirCap(cirCap), .eirCap(eirCap),
    .refillTick(refillTick), .portBackpressure(portBackpressure),
    .grantReady(grantReady), .grantValid(grantValid),
    .grantQueue(grantQueue), .grantLen(grantLen)
  );

  always_comb begin
    for (int i = 0; i < NQ; i++) begin
      qNonEmpty[i]          = ne[i];
      qHeadLen[i*LW +: LW]  = LW'(hLen[i]);
      qPrio[i*PW +: PW]     = PW'(pri[i]);
      qQuantum[i*LW +: LW]  = LW'(quant[i]);
      cirStep[i*TW +: TW]   = TW'(cS[i]);
      eirStep[i*TW +: TW]   = TW'(eS[i]);
      cirCap[i*TW +: TW]    = TW'(cC[i]);
      eirCap[i*TW +: TW]    = TW'(eC[i]);
    end
  end

  task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic setDefaults(input int m);
    mode = 2'(m);
    refillTick = 1'b0;
    portBackpressure = 1'b0;
    grantReady = 1'b1;
    for (int i = 0; i < NQ; i++) begin
      ne[i] = 1'b0; hLen[i] = 10; pri[i] = 0; quant[i] = 10;
      cS[i] = 4000; eS[i] = 0; cC[i] = 4000; eC[i] = 4000;
    end
  endtask

  task automatic startTest(input int m);
    @(negedge clk);
    rstN = 1'b0;
    setDefaults(m);
  endtask

  task automatic goLive();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  task automatic tickN(input int n);
    refillTick = 1'b1;
    repeat (n) @(negedge clk);
    refillTick = 1'b0;
  endtask

  task automatic getGrant(output int q, output int l, output bit ok);
    ok = 1'b0; q = -1; l = -1;
    for (int c = 0; c < 60; c++) begin
      @(negedge clk);
      if (grantValid) begin
        q = int'(grantQueue); l = int'(grantLen); ok = 1'b1;
        return;
      end
    end
  endtask

  task automatic expectGrant(input string req, input int expQ, input int expL);
    int q, l; bit ok;
    getGrant(q, l, ok);
    chk(ok && q == expQ, req, "granted queue", q, expQ);
    if (expL >= 0) chk(l == expL, req, "granted length", l, expL);
  endtask

  task automatic noGrant(input int n, input string req, input string what);
    int seen = 0;
    repeat (n) begin
      @(negedge clk);
      if (grantValid) seen++;
    end
    chk(seen == 0, req, what, seen, 0);
  endtask

  task automatic testReset();
    startTest(0);
    for (int i = 0; i < NQ; i++) ne[i] = 1'b1;
    cS[0] = 100;
    goLive();
    chk(grantValid == 1'b0, "R1", "valid right after reset", int'(grantValid), 0);
    noGrant(6, "R1", "grants before first refill");
    tickN(1);
    expectGrant("R5", 0, 10);
  endtask

  task automatic testPrio();
    startTest(0);
    for (int i = 0; i < NQ; i++) ne[i] = 1'b1;
    pri[3] = 3; pri[5] = 2;
    goLive();
    tickN(1);
    for (int k = 0; k < 3; k++) expectGrant("R2", 3, -1);
    ne[3] = 1'b0;
    expectGrant("R2", 5, -1);
  endtask

  task automatic testRr();
    startTest(0);
    for (int i = 0; i < NQ; i++) ne[i] = 1'b1;
    goLive();
    tickN(1);
    for (int k = 0; k < 9; k++) expectGrant("R5", k % NQ, -1);
  endtask

  task automatic testSp();
    startTest(2);
    ne[2] = 1'b1; ne[5] = 1'b1;
    goLive();
    tickN(1);
    for (int k = 0; k < 3; k++) expectGrant("R6", 2, -1);
    ne[2] = 1'b0;
    expectGrant("R6", 5, -1);
  endtask

  task automatic testClass();
    startTest(0);
    ne[1] = 1'b1; pri[1] = 3; cS[1] = 0; eS[1] = 100; eC[1] = 100; hLen[1] = 60;
    ne[6] = 1'b1; pri[6] = 0; cS[6] = 100; cC[6] = 100;
    goLive();
    tickN(1);
    expectGrant("R3", 6, 10);
    expectGrant("R3", 6, 10);
    ne[6] = 1'b0;
    expectGrant("R3", 1, 60);
    noGrant(6, "R3", "grants after excess bucket drained to 40");
  endtask

  task automatic testBucket();
    startTest(0);
    ne[0] = 1'b1; hLen[0] = 121; cS[0] = 50; cC[0] = 120;
    goLive();
    tickN(5);
    noGrant(4, "R4", "grants with 121 bytes against cap 120");
    hLen[0] = 120;
    expectGrant("R4", 0, 120);
    noGrant(6, "R4", "grants after bucket drained");
    hLen[0] = 50;
    tickN(1);
    expectGrant("R4", 0, 50);
  endtask

  task automatic testBp();
    startTest(0);
    for (int i = 0; i < NQ; i++) ne[i] = 1'b1;
    portBackpressure = 1'b1;
    goLive();
    tickN(1);
    noGrant(6, "R9", "grants under backpressure");
    portBackpressure = 1'b0;
    expectGrant("R9", 0, -1);
  endtask

  task automatic testHold();
    int stableCnt = 0;
    startTest(0);
    ne[4] = 1'b1; hLen[4] = 33; grantReady = 1'b0;
    goLive();
    tickN(1);
    expectGrant("R10", 4, 33);
    repeat (4) begin
      @(negedge clk);
      if (grantValid && grantQueue == 3'd4 && grantLen == 8'd33) stableCnt++;
    end
    chk(stableCnt == 4, "R10", "cycles grant held stable", stableCnt, 4);
    grantReady = 1'b1;
    @(negedge clk);
    chk(grantValid == 1'b0, "R10", "valid after handshake", int'(grantValid), 0);
  endtask

  task automatic testDwrr();
    int expSeq [8] = '{0, 1, 1, 1, 0, 1, 1, 1};
    startTest(1);
    ne[0] = 1'b1; ne[1] = 1'b1; quant[0] = 10; quant[1] = 30;
    goLive();
    tickN(1);
    for (int k = 0; k < 8; k++) expectGrant("R7", expSeq[k], 10);
  endtask

  task automatic testClear();
    startTest(1);
    ne[0] = 1'b1; quant[0] = 30; hLen[0] = 20;
    goLive();
    tickN(1);
    expectGrant("R8", 0, 20);
    ne[0] = 1'b0;
    repeat (3) @(negedge clk);
    hLen[0] = 10; ne[0] = 1'b1;
    @(negedge clk);
    chk(grantValid == 1'b0, "R8", "valid one cycle after refill of cleared queue", int'(grantValid), 0);
    @(negedge clk);
    chk(grantValid == 1'b1, "R8", "valid after visit cycle", int'(grantValid), 1);
  endtask

  initial begin
    rstN = 1'b0;
    setDefaults(0);
    testReset();
    testPrio();
    testRr();
    testSp();
    testClass();
    testBucket();
    testBp();
    testHold();
    testDwrr();
    testClear();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #500us;
    total++;
    bad++;
    $display("FAIL watchdog all-requirements actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule